// File: doc/BRIEF.md
# Guard-Interval Capture Ping-Pong Buffer

This block sits beside an OFDM receiver with several antenna branches and keeps two short windows from every symbol: the leading guard interval and the trailing stretch of the effective part that the guard interval was copied from. A processor that computes combining weights correlates the two windows, because they carry the same transmitted samples. Each clock of the write domain can carry one complex sample from every branch, given as a signed 16-bit in-phase half in the upper bits and a signed 16-bit quadrature half in the lower bits. A symbol-start strobe marks sample zero. The captured words go into a two-bank buffer. The write side fills one bank while the processor, on its own clock, reads the other.

When the last tail sample of a symbol is stored, that bank is flagged full and the writer moves to the other bank. The flag crosses into the read clock domain, where it raises a one-cycle interrupt. The reader hands the bank back with an acknowledge. If the writer completes a symbol while the other bank is still held by the reader, that symbol is thrown away and a sticky overrun flag is set.

The defaults are a 128-sample guard interval within a 2176-sample symbol, which keeps the elaborated storage at 2048 words. Setting `GI_LEN`=512 and `SYM_LEN`=8704 gives the full-size arrangement: 8K words of 32 bits across both banks. `GI_LEN` must be a power of two.

Top module: `gi_pingpong_capture`

## Requirements
- R1: After a synchronous reset, `bank_full` is 00, `irq` is 0 and `overrun` is 0, and the first completed symbol goes to bank 0.
- R2: A capture begins only in a cycle where `smp_vld`, `sym_start` and `run_en` are all high. A symbol strobe while `run_en` is low, and valid samples with no strobe while idle, store nothing and flag nothing.
- R3: The sample index counts valid samples from 0 at the strobe. Indices 0..GI_LEN-1 form the head window and SYM_LEN-GI_LEN..SYM_LEN-1 form the tail window. Samples between the two windows are not stored.
- R4: The read address is {bank (MSB), window (0 head, 1 tail), branch, index (LSBs)}. Branch k is taken from `br_data[k*32 +: 32]` and is stored unchanged, so the I/Q packing is preserved.
- R5: The valid sample at index SYM_LEN-1 marks the current write bank full and switches writing to the other bank.
- R6: Each bank's full flag appears on `bank_full` through a two-flop synchronizer in the read domain. Each rising flag bit gives exactly one `irq` pulse, one `rd_clk` cycle wide.
- R7: `rd_ack[b]` clears bank b's full flag when `bank_full[b]` is 1, and `bank_full[b]` falls a few cycles later. An acknowledge of a bank that is not full has no effect.
- R8: If a symbol completes while the other bank is full, that symbol is dropped: no bank is flagged, no interrupt is raised, the writer stays on the same bank, the reader's bank keeps its contents, and `overrun` is set and stays set until reset.
- R9: A strobe that arrives in the middle of a capture restarts the index at 0, and the new symbol is the one stored.
- R10: `rd_data` presents the word addressed in a cycle with `rd_en` high after two `rd_clk` edges, and holds its value while no read is in flight.
- R11: Cycles with `smp_vld` low neither advance the index nor write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Sample-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| run_en | input | 1 | Allows a new capture to begin |
| sym_start | input | 1 | Marks sample index 0 of a symbol |
| smp_vld | input | 1 | A sample set is present on `br_data` |
| br_data | input | NBR*DW | Branch samples, branch k in bits k*DW +: DW |
| overrun | output | 1 | Sticky flag: a symbol was dropped |
| rd_clk | input | 1 | Processor-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | {bank, window, branch, index} |
| rd_ack | input | 2 | Per-bank release of a full bank |
| rd_data | output | DW | Read word, two cycles after the request |
| bank_full | output | 2 | Per-bank full flag, read domain |
| irq | output | 1 | One-cycle pulse when a bank becomes full |

## Verification
A wrong sample counter or window decode would put the wrong words at the head or tail addresses. This shows up in the first bank read after a single symbol. Bank bookkeeping errors, such as a missed toggle, a mark on a dropped symbol or an unguarded overwrite, show up as a wrong `bank_full` pattern or as stale data within one or two symbols. A broken acknowledge path shows up as a flag that never falls within a short poll window. An interrupt that is too wide or missing shows up in the pulse count and pulse width after the flag rises.

// File: rtl/gi_cap_pkg.sv
package gi_cap_pkg;

  typedef enum logic {
    WIN_HEAD = 1'b0,
    WIN_TAIL = 1'b1
  } win_e;

  // Bits needed to index n items (at least one)
  function automatic int unsigned idx_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/gi_sync2.sv
module gi_sync2 #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end

endmodule

// File: rtl/gi_bank_ram.sv
module gi_bank_ram #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/gi_wr_ctrl.sv
module gi_wr_ctrl
  import gi_cap_pkg::*;
#(
  parameter int unsigned GI_LEN  = 128,
  parameter int unsigned SYM_LEN = 2176,
  localparam int unsigned GB = idx_bits(GI_LEN),
  localparam int unsigned WA = GB + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_en,
  input  logic          sym_start,
  input  logic          smp_vld,
  input  logic [1:0]    ack_tog_s,
  output logic          wr_en,
  output logic [WA-1:0] wr_addr,
  output logic [1:0]    full_w,
  output logic          overrun
);

  localparam int unsigned CB    = idx_bits(SYM_LEN);
  localparam int unsigned TAIL0 = SYM_LEN - GI_LEN;

  logic          active, wbank;
  logic [CB-1:0] cnt, idx;
  logic [1:0]    ack_d, clr, full_nx;
  logic          start, take, last, in_head, in_tail;
  logic [GB-1:0] off;
  win_e          win;

  always_comb begin
    start   = smp_vld & sym_start & run_en;
    take    = smp_vld & (start | active);
    idx     = start ? '0 : cnt;
    in_head = (idx < CB'(GI_LEN));
    in_tail = (idx >= CB'(TAIL0));
    last    = take & (idx == CB'(SYM_LEN - 1));
    win     = in_head ? WIN_HEAD : WIN_TAIL;
    off     = in_head ? idx[GB-1:0] : GB'(idx - CB'(TAIL0));
    wr_en   = take & (in_head | in_tail);
    wr_addr = {wbank, win, off};
    clr     = ack_tog_s ^ ack_d;
    full_nx = full_w & ~clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      wbank   <= 1'b0;
      cnt     <= '0;
      ack_d   <= '0;
      full_w  <= '0;
      overrun <= 1'b0;
    end else begin
      ack_d  <= ack_tog_s;
      full_w <= full_nx;
      if (take) begin
        if (last) begin
          active <= 1'b0;
          cnt    <= '0;
          if (full_nx[~wbank]) begin
            overrun <= 1'b1;
          end else begin
            full_w <= full_nx | (2'b01 << wbank);
            wbank  <= ~wbank;
          end
        end else begin
          active <= 1'b1;
          cnt    <= idx + 1'b1;
        end
      end
    end
  end

  // R8: a bank held by the reader is never written
  p_no_write_full_r8: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full_w[wbank]);

  // R8: overrun stays set once raised
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  // R3: index stays inside a symbol
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (rst)
    active |-> (int'(cnt) < SYM_LEN));

  // R5: the bank being left is flagged full when writing switches
  p_bank_flip_r5: assert property (@(posedge clk) disable iff (rst)
    (wbank != $past(wbank)) |-> full_w[$past(wbank)]);

  // R5: at most one bank becomes full per cycle
  p_one_mark_r5: assert property (@(posedge clk) disable iff (rst)
    $countones(full_w & ~$past(full_w)) <= 1);

endmodule

// File: rtl/gi_rd_status.sv
module gi_rd_status (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] full_async,
  input  logic [1:0] rd_ack,
  output logic [1:0] bank_full,
  output logic       irq,
  output logic [1:0] ack_tog
);

  logic [1:0] full_r, full_d, pend, acc;

  gi_sync2 #(.W(2)) u_full_sync (
    .clk (clk),
    .rst (rst),
    .d   (full_async),
    .q   (full_r)
  );

  assign acc       = rd_ack & full_r & ~pend;
  assign bank_full = full_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_d  <= '0;
      irq     <= 1'b0;
      ack_tog <= '0;
      pend    <= '0;
    end else begin
      full_d  <= full_r;
      irq     <= |(full_r & ~full_d);
      ack_tog <= ack_tog ^ acc;
      pend    <= (pend | acc) & full_r;
    end
  end

  // R6: the interrupt lasts one cycle
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R6: an interrupt only accompanies a full bank
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (bank_full != 2'b00));

  // R7: an accepted release is only toggled once per full period
  p_ack_once_r7: assert property (@(posedge clk) disable iff (rst)
    (pend[0] && full_r[0]) |=> (ack_tog[0] == $past(ack_tog[0])));

endmodule

// File: rtl/gi_pingpong_capture.sv
module gi_pingpong_capture
  import gi_cap_pkg::*;
#(
  parameter int unsigned NBR     = 4,
  parameter int unsigned DW      = 32,
  parameter int unsigned GI_LEN  = 128,
  parameter int unsigned SYM_LEN = 2176,
  localparam int unsigned GB = idx_bits(GI_LEN),
  localparam int unsigned BB = idx_bits(NBR),
  localparam int unsigned AW = 2 + BB + GB
) (
  input  logic              wr_clk,
  input  logic              wr_rst,
  input  logic              run_en,
  input  logic              sym_start,
  input  logic              smp_vld,
  input  logic [NBR*DW-1:0] br_data,
  output logic              overrun,
  input  logic              rd_clk,
  input  logic              rd_rst,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic [1:0]        rd_ack,
  output logic [DW-1:0]     rd_data,
  output logic [1:0]        bank_full,
  output logic              irq
);

  localparam int unsigned RA = GB + 2;

  logic          wr_en;
  logic [RA-1:0] wr_addr;
  logic [RA-1:0] ram_raddr;
  logic [1:0]    full_w, ack_tog, ack_tog_s;
  logic [DW-1:0] rq [NBR];
  logic [BB-1:0] rsel_q;
  logic          rvld_q;

  gi_wr_ctrl #(.GI_LEN(GI_LEN), .SYM_LEN(SYM_LEN)) u_wr (
    .clk       (wr_clk),
    .rst       (wr_rst),
    .run_en    (run_en),
    .sym_start (sym_start),
    .smp_vld   (smp_vld),
    .ack_tog_s (ack_tog_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .full_w    (full_w),
    .overrun   (overrun)
  );

  gi_sync2 #(.W(2)) u_ack_sync (
    .clk (wr_clk),
    .rst (wr_rst),
    .d   (ack_tog),
    .q   (ack_tog_s)
  );

  gi_rd_status u_rd (
    .clk        (rd_clk),
    .rst        (rd_rst),
    .full_async (full_w),
    .rd_ack     (rd_ack),
    .bank_full  (bank_full),
    .irq        (irq),
    .ack_tog    (ack_tog)
  );

  assign ram_raddr = {rd_addr[AW-1:AW-2], rd_addr[GB-1:0]};

  for (genvar g = 0; g < NBR; g++) begin : g_branch
    gi_bank_ram #(.DW(DW), .AW(RA)) u_ram (
      .wclk  (wr_clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (br_data[g*DW +: DW]),
      .rclk  (rd_clk),
      .re    (rd_en),
      .raddr (ram_raddr),
      .rdata (rq[g])
    );
  end

  always_ff @(posedge rd_clk) begin
    if (rd_rst) begin
      rvld_q  <= 1'b0;
      rsel_q  <= '0;
      rd_data <= '0;
    end else begin
      rvld_q <= rd_en;
      if (rd_en) rsel_q <= rd_addr[GB +: BB];
      if (rvld_q) rd_data <= (int'(rsel_q) < NBR) ? rq[rsel_q] : '0;
    end
  end

  // R10: with no read in flight the output word holds
  p_rd_hold_r10: assert property (@(posedge rd_clk) disable iff (rd_rst)
    (!rvld_q && !$past(rvld_q)) |=> $stable(rd_data));

endmodule

// File: tb/tb_gi_pingpong_capture.sv
module tb_gi_pingpong_capture;

  localparam int G = 8, SYM = 40, NBR = 4, DW = 32, GB = 3, BB = 2, AW = 7;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic run_en = 0, sym_start = 0, smp_vld = 0;
  logic [NBR*DW-1:0] br_data = '0;
  logic rd_en = 0;
  logic [AW-1:0] rd_addr = '0;
  logic [1:0] rd_ack = '0;
  logic overrun, irq;
  logic [1:0] bank_full;
  logic [DW-1:0] rd_data;

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  gi_pingpong_capture #(.NBR(NBR), .DW(DW), .GI_LEN(G), .SYM_LEN(SYM)) dut (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .run_en(run_en), .sym_start(sym_start),
    .smp_vld(smp_vld), .br_data(br_data), .overrun(overrun),
    .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .bank_full(bank_full), .irq(irq));

  int n_chk = 0, n_err = 0, irq_cnt = 0, irq_wide = 0;
  bit irq_prev = 0, done = 0;
  logic [DW-1:0] symd [NBR][SYM];
  logic [DW-1:0] expm [2][2][NBR][G];

  always @(negedge rd_clk) begin
    if (!rd_rst) begin
      if (irq) irq_cnt++;
      if (irq && irq_prev) irq_wide++;
      irq_prev = irq;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'($urandom);
  endfunction

  task automatic gen_sym();
    for (int b = 0; b < NBR; b++)
      for (int i = 0; i < SYM; i++) symd[b][i] = rnd_word();
  endtask

  // Drive n samples; strobe on the first one when with_start is set
  task automatic drive_sym(input int gap_pct, input int n, input bit with_start);
    for (int i = 0; i < n; i++) begin
      while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
        @(negedge wr_clk);
        smp_vld = 0; sym_start = 0; br_data = {NBR*DW{1'b1}};
      end
      @(negedge wr_clk);
      smp_vld = 1;
      sym_start = with_start && (i == 0);
      for (int b = 0; b < NBR; b++) br_data[b*DW +: DW] = symd[b][i];
    end
    @(negedge wr_clk);
    smp_vld = 0; sym_start = 0;
  endtask

  function automatic void save_exp(input int bank);
    for (int b = 0; b < NBR; b++)
      for (int i = 0; i < G; i++) begin
        expm[bank][0][b][i] = symd[b][i];
        expm[bank][1][b][i] = symd[b][SYM-G+i];
      end
  endfunction

  task automatic wait_rd(input int n);
    for (int i = 0; i < n; i++) @(negedge rd_clk);
  endtask

  task automatic wait_full(input logic [1:0] exp, input string req);
    int t = 0;
    while (bank_full !== exp && t < 200) begin
      @(negedge rd_clk);
      t++;
    end
    chk(bank_full === exp, req, "bank_full", bank_full, exp);
  endtask

  task automatic do_ack(input logic [1:0] m);
    @(negedge rd_clk); rd_ack = m;
    @(negedge rd_clk); rd_ack = '0;
  endtask

  task automatic read_bank(input int bank, input string req);
    int bad = 0;
    logic [DW-1:0] fa = '0, fe = '0, held;
    for (int w = 0; w < 2; w++)
      for (int b = 0; b < NBR; b++)
        for (int i = 0; i < G; i++) begin
          @(negedge rd_clk);
          rd_en = 1;
          rd_addr = {1'(bank), 1'(w), BB'(b), GB'(i)};
          @(negedge rd_clk);
          rd_en = 0;
          @(negedge rd_clk);
          if (rd_data !== expm[bank][w][b][i]) begin
            if (bad == 0) begin fa = rd_data; fe = expm[bank][w][b][i]; end
            bad++;
          end
        end
    chk(bad == 0, req, $sformatf("bank %0d contents", bank), fa, fe);
    held = rd_data;
    wait_rd(4);
    chk(rd_data === held, "R10", "rd_data hold", rd_data, held);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int wb, ic;
    void'($urandom(32'h5eed_0123));
    wait_rd(5);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    wait_rd(2);
    // R1: reset state
    chk(bank_full === 2'b00, "R1", "bank_full", bank_full, 0);
    chk(irq === 1'b0, "R1", "irq", irq, 0);
    chk(overrun === 1'b0, "R1", "overrun", overrun, 0);
    run_en = 1;

    // Symbol A -> bank 0 (R1, R5, R6, R3, R4)
    gen_sym(); drive_sym(0, SYM, 1); save_exp(0);
    wait_full(2'b01, "R5");
    wait_rd(4);
    chk(irq_cnt == 1, "R6", "irq pulses", irq_cnt, 1);
    chk(irq_wide == 0, "R6", "irq wide cycles", irq_wide, 0);
    read_bank(0, "R4");

    // Symbol B while bank 0 held -> dropped (R8)
    gen_sym(); drive_sym(0, SYM, 1);
    wait_rd(30);
    chk(bank_full === 2'b01, "R8", "bank_full after drop", bank_full, 1);
    chk(irq_cnt == 1, "R8", "no irq on drop", irq_cnt, 1);
    chk(overrun === 1'b1, "R8", "overrun", overrun, 1);
    read_bank(0, "R8");

    // Release bank 0 (R7); stray release of bank 1 is ignored
    do_ack(2'b01);
    wait_full(2'b00, "R7");
    do_ack(2'b10);
    wait_rd(20);
    // Symbol C -> bank 1, the writer stayed on bank 1 after the drop (R8, R5)
    gen_sym(); drive_sym(0, SYM, 1); save_exp(1);
    wait_full(2'b10, "R8");
    wait_rd(20);
    chk(bank_full === 2'b10, "R7", "stray ack ignored", bank_full, 2);
    read_bank(1, "R3");
    do_ack(2'b10);
    wait_full(2'b00, "R7");

    // Symbol D with sample gaps -> bank 0 (R11)
    gen_sym(); drive_sym(50, SYM, 1); save_exp(0);
    wait_full(2'b01, "R11");
    read_bank(0, "R11");
    do_ack(2'b01);
    wait_full(2'b00, "R7");

    // Run enable low, then samples without a strobe (R2)
    ic = irq_cnt;
    run_en = 0;
    gen_sym(); drive_sym(0, SYM, 1);
    run_en = 1;
    gen_sym(); drive_sym(0, SYM, 0);
    wait_rd(30);
    chk(bank_full === 2'b00, "R2", "no capture", bank_full, 0);
    chk(irq_cnt == ic, "R2", "no irq", irq_cnt, ic);

    // Restart in mid-symbol (R9) -> bank 1
    gen_sym(); drive_sym(0, 15, 1);
    gen_sym(); drive_sym(0, SYM, 1); save_exp(1);
    wait_full(2'b10, "R9");
    read_bank(1, "R9");
    do_ack(2'b10);
    wait_full(2'b00, "R7");

    // Random symbols alternating banks
    wb = 0;
    for (int k = 0; k < 4; k++) begin
      gen_sym(); drive_sym(int'($urandom % 40), SYM, 1); save_exp(wb);
      wait_full(2'(1 << wb), "R5");
      read_bank(wb, "R3");
      do_ack(2'(1 << wb));
      wait_full(2'b00, "R7");
      wb ^= 1;
    end
    wait_rd(4);
    chk(irq_wide == 0, "R6", "irq wide cycles", irq_wide, 0);
    chk(overrun === 1'b1, "R8", "overrun sticky", overrun, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule